// File: doc/BRIEF.md
# Packed Shift-Right-and-Insert Unit

This block performs a packed right shift with insertion on operands up to 128 bits wide. One operation carries a source operand, the current destination operand and a 7-bit immediate split into a 4-bit upper part and a 3-bit lower part. It also carries a width-select bit and a scalar/vector mode bit. The block decodes the element size and shift amount from the immediate. Each source element is shifted right logically, and bits shifted past the low end of the element are discarded. In each element, the vacated high bit positions keep the bits of the old destination rather than being filled with zeros. Encodings that are undefined or reserved are flagged instead of executed.

The block has one register stage. Operations enter on a valid/ready handshake. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). An operation accepted at a clock edge appears on the outputs right after that edge. `out_valid` stays high, with data and flag held, until `out_ready` is sampled high. While `out_ready` is held high the unit accepts one operation per cycle. A synchronous active-high reset empties the output register.

Top module: `sri_unit`

## Requirements
- R1: In vector mode the element size is 8 shifted left by the index of the highest set bit of `in_imm_hi`: bit 0 gives 8, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64.
- R2: The shift amount is twice the element size minus the unsigned 7-bit value {`in_imm_hi`,`in_imm_lo`}. This gives 1 up to the element size.
- R3: In each element, result bit p takes source bit p+shift when p+shift is less than the element size. Otherwise it takes destination bit p. Source bits below position shift are lost.
- R4: A shift equal to the element size returns the destination element unchanged.
- R5: In vector mode the active width is 128 bits when `in_q`=1 and 64 bits when `in_q`=0. In every 64-bit operation (vector with `in_q`=0, or scalar) bits 127:64 of the result are zero.
- R6: In vector mode, `in_imm_hi`=0000 raises `out_illegal`.
- R7: In vector mode, `in_imm_hi[3]`=1 together with `in_q`=0 raises `out_illegal`.
- R8: In scalar mode (`in_scalar`=1) there is one 64-bit element and `in_q` is ignored. `in_imm_hi[3]`=0 raises `out_illegal`. Otherwise the shift is 128 minus the immediate.
- R9: When `out_illegal` is 1, `out_data` is all zeros and `out_valid` still presents the result.
- R10: An operation accepted at an edge appears on the outputs directly after that edge. Reset clears `out_valid`.
- R11: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_imm_hi | input | 4 | Upper immediate field |
| in_imm_lo | input | 3 | Lower immediate field |
| in_q | input | 1 | Vector width select: 0 is 64 bits, 1 is 128 bits |
| in_scalar | input | 1 | 1 selects the scalar form |
| in_src | input | 128 | Source operand |
| in_dst | input | 128 | Old destination operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result |
| out_illegal | output | 1 | Encoding was undefined or reserved |

## Verification
The hardest condition to reach from the ports is a shift exactly equal to the element width, for every element size. Only one immediate value per size produces it, so random immediates seldom hit it. Directed operations place the immediate at the bottom of each size band to produce it. The directed set also covers the other band edges, shift 1 and the two reserved forms. A long random phase follows. In that phase `out_ready` and `in_valid` are toggled independently, so operations arrive while the output is stalled and while it is draining. A behavioural per-bit model checks every cycle.

// File: rtl/sri_pkg.sv
package sri_pkg;
  localparam int IMM_HI_W = 4;
  localparam int IMM_LO_W = 3;
  localparam int IMM_W    = IMM_HI_W + IMM_LO_W;
  localparam int ELEM_MIN = 8;
  localparam int N_SIZES  = IMM_HI_W;
  localparam int SIZE_IW  = $clog2(N_SIZES);

  typedef struct packed {
    logic [SIZE_IW-1:0] size_idx;
    logic [IMM_W-1:0]   shift;
    logic               illegal;
    logic               wide;
  } sri_dec_t;
endpackage

// File: rtl/sri_decode.sv
module sri_decode
  import sri_pkg::*;
(
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic                q,
  input  logic                scalar,
  output sri_dec_t            dec
);
  localparam int SW = IMM_W + 1;

  logic [SIZE_IW-1:0] top_idx;
  logic [SW-1:0]      imm_full;
  logic [SW-1:0]      twice_size;
  logic [SW-1:0]      shift_full;

  always_comb begin
    top_idx = '0;
    for (int k = 0; k < N_SIZES; k++) begin
      if (imm_hi[k]) top_idx = SIZE_IW'(k);
    end
  end

  assign imm_full = SW'({imm_hi, imm_lo});

  always_comb begin
    dec = '0;
    if (scalar) begin
      dec.size_idx = SIZE_IW'(N_SIZES - 1);
      dec.illegal  = !imm_hi[IMM_HI_W-1];
      dec.wide     = 1'b0;
    end else begin
      dec.size_idx = top_idx;
      dec.illegal  = (imm_hi == '0) || (imm_hi[IMM_HI_W-1] && !q);
      dec.wide     = q;
    end
    twice_size = SW'(ELEM_MIN * 2) << dec.size_idx;
    shift_full = twice_size - imm_full;
    dec.shift  = shift_full[IMM_W-1:0];
  end
endmodule

// File: rtl/sri_lane.sv
module sri_lane #(
  parameter int ELEM_W  = 8,
  parameter int SHIFT_W = 7
) (
  input  logic [ELEM_W-1:0]  src,
  input  logic [ELEM_W-1:0]  dst,
  input  logic [SHIFT_W-1:0] shift,
  output logic [ELEM_W-1:0]  res
);
  logic [ELEM_W-1:0] keep_mask;
  logic [ELEM_W-1:0] moved;

  assign keep_mask = {ELEM_W{1'b1}} >> shift;
  assign moved     = src >> shift;
  assign res       = (dst & ~keep_mask) | moved;
endmodule

// File: rtl/sri_bank.sv
module sri_bank #(
  parameter int DATA_W  = 128,
  parameter int ELEM_W  = 8,
  parameter int SHIFT_W = 7
) (
  input  logic [DATA_W-1:0]  src,
  input  logic [DATA_W-1:0]  dst,
  input  logic [SHIFT_W-1:0] shift,
  output logic [DATA_W-1:0]  res
);
  localparam int LANES = DATA_W / ELEM_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    sri_lane #(.ELEM_W(ELEM_W), .SHIFT_W(SHIFT_W)) u_lane (
      .src   (src[j*ELEM_W +: ELEM_W]),
      .dst   (dst[j*ELEM_W +: ELEM_W]),
      .shift (shift),
      .res   (res[j*ELEM_W +: ELEM_W])
    );
  end
endmodule

// File: rtl/sri_unit.sv
module sri_unit
  import sri_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IMM_HI_W-1:0] in_imm_hi,
  input  logic [IMM_LO_W-1:0] in_imm_lo,
  input  logic                in_q,
  input  logic                in_scalar,
  input  logic [DATA_W-1:0]   in_src,
  input  logic [DATA_W-1:0]   in_dst,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_illegal
);
  localparam int HALF = DATA_W / 2;

  sri_dec_t    dec;
  logic [DATA_W-1:0] bank_res [N_SIZES];
  logic [DATA_W-1:0] sel_res;
  logic [DATA_W-1:0] next_data;

  sri_decode u_decode (
    .imm_hi (in_imm_hi),
    .imm_lo (in_imm_lo),
    .q      (in_q),
    .scalar (in_scalar),
    .dec    (dec)
  );

  for (genvar k = 0; k < N_SIZES; k++) begin : g_size
    sri_bank #(.DATA_W(DATA_W), .ELEM_W(ELEM_MIN << k), .SHIFT_W(IMM_W)) u_bank (
      .src   (in_src),
      .dst   (in_dst),
      .shift (dec.shift),
      .res   (bank_res[k])
    );
  end

  always_comb begin
    sel_res = bank_res[dec.size_idx];
    if (dec.illegal)      next_data = '0;
    else if (!dec.wide)   next_data = {{HALF{1'b0}}, sel_res[HALF-1:0]};
    else                  next_data = sel_res;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
    if (in_valid && in_ready) begin
      out_data    <= next_data;
      out_illegal <= dec.illegal;
    end
  end

  // R10
  reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !out_valid);
  // R10
  accept_yields_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_data == '0));
  // R6
  vec_zero_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_scalar && in_imm_hi == '0) |=> out_illegal);
  // R8
  scalar_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_scalar && !in_imm_hi[IMM_HI_W-1]) |=> out_illegal);
  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_scalar || !in_q)) |=> (out_data[DATA_W-1:HALF] == '0));
endmodule

// File: tb/sri_unit_bench.sv
`timescale 1ns/1ps
module sri_unit_bench;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [3:0]   in_imm_hi;
  logic [2:0]   in_imm_lo;
  logic         in_q;
  logic         in_scalar;
  logic [127:0] in_src;
  logic [127:0] in_dst;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic         out_illegal;

  int checks = 0;
  int fails  = 0;

  logic         m_valid;
  logic [127:0] m_data;
  logic         m_ill;

  always #2.5 clk = ~clk;

  sri_unit u_sri_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_imm_hi(in_imm_hi), .in_imm_lo(in_imm_lo), .in_q(in_q),
    .in_scalar(in_scalar), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  function automatic void model_op(input logic [3:0] hi, input logic [2:0] lo,
                                   input logic q, input logic sc,
                                   input logic [127:0] s, input logic [127:0] d,
                                   output logic [127:0] r, output logic ill);
    int imm, es, sh, nb;
    imm = int'(hi) * 8 + int'(lo);
    if (sc) begin
      ill = !hi[3]; es = 64; sh = 128 - imm; nb = 64;
    end else begin
      ill = (hi == 0) || (hi[3] && !q);
      es  = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
      sh  = 2 * es - imm;
      nb  = q ? 128 : 64;
    end
    r = '0;
    if (!ill) begin
      for (int b = 0; b < nb; b++) begin
        int e, p;
        e = b / es; p = b % es;
        if (p + sh < es) r[b] = s[e*es + p + sh];
        else             r[b] = d[b];
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    logic acc;
    logic [127:0] nd;
    logic ni;
    #1;
    check("R11", "in_ready", 128'(in_ready), 128'(!m_valid || out_ready));
    acc = in_valid && (!m_valid || out_ready);
    model_op(in_imm_hi, in_imm_lo, in_q, in_scalar, in_src, in_dst, nd, ni);
    @(posedge clk);
    if (rst) m_valid = 0;
    else if (!m_valid || out_ready) m_valid = in_valid;
    if (acc) begin m_data = nd; m_ill = ni; end
    #1;
    check(rst ? "R10" : tag, "out_valid", 128'(out_valid), 128'(m_valid));
    if (m_valid) begin
      check(tag, "out_data", out_data, m_data);
      check(tag, "out_illegal", 128'(out_illegal), 128'(m_ill));
    end
  endtask

  task automatic op(input string tag, input logic [3:0] hi, input logic [2:0] lo,
                    input logic q, input logic sc);
    in_valid = 1; in_imm_hi = hi; in_imm_lo = lo; in_q = q; in_scalar = sc;
    in_src = {$urandom, $urandom, $urandom, $urandom};
    in_dst = {$urandom, $urandom, $urandom, $urandom};
    cycle(tag);
    in_valid = 0;
    cycle(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_valid = 0; m_data = '0; m_ill = 0;
    rst = 1; in_valid = 0; out_ready = 1;
    in_imm_hi = 0; in_imm_lo = 0; in_q = 0; in_scalar = 0;
    in_src = '0; in_dst = '0;
    repeat (3) cycle("R10");
    rst = 0;
    // R1 R2 R3: each element size, mid-band shifts
    op("R1", 4'b0001, 3'b101, 1, 0);   // 8-bit, shift 3
    op("R1", 4'b0011, 3'b011, 1, 0);   // 16-bit, shift 5
    op("R2", 4'b0111, 3'b111, 0, 0);   // 32-bit, shift 1
    op("R3", 4'b1010, 3'b001, 1, 0);   // 64-bit, shift 47
    // R4: shift equals element width
    op("R4", 4'b0001, 3'b000, 1, 0);
    op("R4", 4'b0010, 3'b000, 1, 0);
    op("R4", 4'b0100, 3'b000, 0, 0);
    op("R4", 4'b1000, 3'b000, 1, 0);
    // R5: 64-bit active width
    op("R5", 4'b0101, 3'b010, 0, 0);
    // R6 R7 illegal vector forms
    op("R6", 4'b0000, 3'b110, 1, 0);
    op("R7", 4'b1100, 3'b011, 0, 0);
    // R8 scalar forms
    op("R8", 4'b1111, 3'b111, 1, 1);   // shift 1, q ignored
    op("R8", 4'b1000, 3'b000, 0, 1);   // shift 64
    op("R8", 4'b0101, 3'b000, 0, 1);   // illegal
    op("R9", 4'b0000, 3'b000, 0, 0);
    // R11: back-pressure, stall then drain
    out_ready = 0;
    op("R11", 4'b0011, 3'b001, 1, 0);
    in_valid = 1; cycle("R11");
    out_ready = 1; cycle("R11");
    in_valid = 0; cycle("R11");
    // R3 R10 R11 random traffic
    for (int i = 0; i < 2000; i++) begin
      in_valid  = $urandom_range(0, 3) != 0;
      out_ready = $urandom_range(0, 3) != 0;
      in_imm_hi = 4'($urandom); in_imm_lo = 3'($urandom);
      in_q = 1'($urandom); in_scalar = $urandom_range(0, 4) == 0;
      in_src = {$urandom, $urandom, $urandom, $urandom};
      in_dst = {$urandom, $urandom, $urandom, $urandom};
      cycle("R3");
    end
    in_valid = 0; out_ready = 1;
    cycle("R10");
    rst = 1; cycle("R10"); rst = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule